// File: doc/BRIEF.md
# VCO Coarse-Band Calibrator

This block picks the coarse band of a switched-capacitor VCO before a PLL's fine loop takes over. It does not search for the band. It counts VCO cycles over one reference period with the switch code forced to all zeros, and again with it forced to all ones. From these two endpoint counts and the requested division ratio it interpolates the switch code directly. A calibration therefore lasts six reference periods, however many switch bits the oscillator has.

The block runs on a system clock that is much faster than the reference. The reference boundary arrives as `ref_tick`, a one-clock strobe. Each VCO cycle arrives as `vco_tick`, a one-clock strobe that has already been brought into the system clock domain. A `start` pulse arms the block, and calibration begins at the next reference strobe. The code is applied with a one-clock `done` pulse, and it stays on the switches until a later calibration replaces it.

The reference period must be at least four system clocks longer than the divider's dividend width. With the default parameters the dividend is 24 bits wide, so a reference period needs at least 28 system clocks.

Top module: `vco_band_cal`

## Requirements
- R1: While reset is held, and after it, `band_code` is 0 and `busy`, `done` and `cal_fault` are 0.
- R2: A `start` accepted while idle latches `est_ratio`. The first `ref_tick` after that begins period 1. Throughout periods 1 and 2, `band_code` is all zeros. The VCO strobes counted over period 2 form the low count. The counting window runs from the strobe that opens period 2 up to the clock before the strobe that closes it.
- R3: Throughout periods 3, 4 and 5, `band_code` is all ones. The VCO strobes counted over period 4 form the high count.
- R4: One clock after the strobe that opens period 6, `band_code` takes the value floor(((EST−LO)·(2^N−1) + floor((HI−LO)/2)) / (HI−LO)), where N is the code width.
- R5: If EST ≤ LO the applied code is 0. If EST ≥ HI it is 2^N−1. Both hold when HI > LO.
- R6: If HI ≤ LO, the applied code is 2^(N−1) and `cal_fault` rises with it. `cal_fault` stays high until the next accepted `start`.
- R7: `done` is high for exactly the one clock in which the final code first appears. `busy` is high from the clock after an accepted `start` until the strobe that closes period 6.
- R8: A `start` while `busy` is high is ignored. The code that is applied uses the ratio latched at the accepted start.
- R9: The VCO cycle counter stops at 2^16−1 instead of wrapping.
- R10: While idle, and while armed before period 1, `band_code` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-clock request to calibrate |
| est_ratio | input | 16 | Target VCO cycles per reference period |
| ref_tick | input | 1 | One-clock strobe at each reference period boundary |
| vco_tick | input | 1 | One-clock strobe per VCO cycle, already synchronized |
| band_code | output | 7 | Switch code driven to the VCO |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-clock pulse when the final code is applied |
| cal_fault | output | 1 | High-end count did not exceed low-end count |

## Verification
The interpolation is driven with VCO strobe densities that give distinct low and high counts. Targets are set in the middle of the span, exactly on each endpoint, and outside it on both sides. These cases separate the rounded quotient from the two clamps. Swapping the densities, so that the high count is below the low count, isolates the fault path and the mid-scale code. A long fourth period with a strobe on every clock pushes the counter past its limit, which shows whether it saturates or wraps. A second start pulse with a different ratio is injected in the middle of a run, and the resulting code shows whether the ratio was wrongly re-latched.

// File: rtl/band_cal_pkg.sv
package band_cal_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARM,
        PH_LO_SET,
        PH_LO_CNT,
        PH_HI_SET,
        PH_HI_CNT,
        PH_CALC,
        PH_APPLY
    } cal_phase_e;

endpackage

// File: rtl/vco_cycle_counter.sv
module vco_cycle_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             vco_tick,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Restart at every reference boundary; the strobe on that clock opens the new window.
    always_comb begin
        cnt_d = cnt_q;
        if (ref_tick) begin
            cnt_d = vco_tick ? CNT_W'(1) : '0;
        end else if (vco_tick && (cnt_q != '1)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/band_restoring_divider.sv
module band_restoring_divider #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] numer,
    input  logic [DEN_W-1:0] denom,
    output logic [NUM_W-1:0] quot_o
);

    localparam int STEP_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic [DEN_W-1:0]  rem;
        logic [NUM_W-1:0]  quo;
        logic [DEN_W-1:0]  den;
        logic [STEP_W-1:0] step;
        logic              run;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [DEN_W:0] partial;
    logic           take;

    always_comb begin
        s_d     = s_q;
        partial = {s_q.rem, s_q.quo[NUM_W-1]};
        take    = partial >= {1'b0, s_q.den};
        if (go) begin
            s_d.rem  = '0;
            s_d.quo  = numer;
            s_d.den  = denom;
            s_d.step = '0;
            s_d.run  = 1'b1;
        end else if (s_q.run) begin
            s_d.rem  = take ? DEN_W'(partial - {1'b0, s_q.den}) : partial[DEN_W-1:0];
            s_d.quo  = {s_q.quo[NUM_W-2:0], take};
            s_d.step = s_q.step + STEP_W'(1);
            if (s_q.step == STEP_W'(NUM_W - 1)) s_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign quot_o = s_q.quo;

endmodule

// File: rtl/band_code_select.sv
module band_code_select #(
    parameter int CODE_W = 7,
    parameter int CMP_W  = 16,
    parameter int NUM_W  = 24
) (
    input  logic [CMP_W-1:0]  est_v,
    input  logic [CMP_W-1:0]  lo_v,
    input  logic [CMP_W-1:0]  hi_v,
    input  logic [NUM_W-1:0]  quot,
    output logic [CODE_W-1:0] code_o,
    output logic              fault_o
);

    localparam logic [CODE_W-1:0] MID_CODE  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] FULL_CODE = '1;

    always_comb begin
        fault_o = 1'b0;
        if (hi_v <= lo_v) begin
            code_o  = MID_CODE;
            fault_o = 1'b1;
        end else if (est_v <= lo_v) begin
            code_o = '0;
        end else if (est_v >= hi_v) begin
            code_o = FULL_CODE;
        end else if (quot > NUM_W'(FULL_CODE)) begin
            code_o = FULL_CODE;
        end else begin
            code_o = quot[CODE_W-1:0];
        end
    end

endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal
    import band_cal_pkg::*;
#(
    parameter int CODE_W  = 7,
    parameter int CNT_W   = 16,
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RATIO_W-1:0] est_ratio,
    input  logic               ref_tick,
    input  logic               vco_tick,
    output logic [CODE_W-1:0]  band_code,
    output logic               busy,
    output logic               done,
    output logic               cal_fault
);

    localparam int CMP_W = (CNT_W > RATIO_W) ? CNT_W : RATIO_W;
    localparam int NUM_W = CMP_W + CODE_W + 1;
    localparam logic [CODE_W-1:0] FULL_CODE = '1;

    typedef struct packed {
        cal_phase_e         phase;
        logic [RATIO_W-1:0] est;
        logic [CNT_W-1:0]   lo;
        logic [CNT_W-1:0]   hi;
        logic [CODE_W-1:0]  code;
        logic               done;
        logic               fault;
        logic               go;
    } cal_state_t;

    cal_state_t st_d, st_q;

    logic [CNT_W-1:0]  cnt_w;
    logic [CMP_W-1:0]  est_x, lo_x, hi_x, span, offs;
    logic [NUM_W-1:0]  numer, quot_w;
    logic [CODE_W-1:0] sel_code;
    logic              sel_fault;
    cal_phase_e        phase_w;
    logic [RATIO_W-1:0] est_w;

    vco_cycle_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .vco_tick (vco_tick),
        .count_o  (cnt_w)
    );

    // Interpolation operands, formed from the latched endpoints and target.
    always_comb begin
        est_x = CMP_W'(st_q.est);
        lo_x  = CMP_W'(st_q.lo);
        hi_x  = CMP_W'(st_q.hi);
        span  = hi_x - lo_x;
        offs  = est_x - lo_x;
        numer = NUM_W'(offs) * NUM_W'(FULL_CODE) + NUM_W'(span >> 1);
    end

    band_restoring_divider #(.NUM_W(NUM_W), .DEN_W(CMP_W)) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (st_q.go),
        .numer  (numer),
        .denom  (span),
        .quot_o (quot_w)
    );

    band_code_select #(.CODE_W(CODE_W), .CMP_W(CMP_W), .NUM_W(NUM_W)) sel_i (
        .est_v   (est_x),
        .lo_v    (lo_x),
        .hi_v    (hi_x),
        .quot    (quot_w),
        .code_o  (sel_code),
        .fault_o (sel_fault)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.go   = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: if (start) begin
                st_d.est   = est_ratio;
                st_d.fault = 1'b0;
                st_d.phase = PH_ARM;
            end
            PH_ARM: if (ref_tick) begin
                st_d.code  = '0;
                st_d.phase = PH_LO_SET;
            end
            PH_LO_SET: if (ref_tick) st_d.phase = PH_LO_CNT;
            PH_LO_CNT: if (ref_tick) begin
                st_d.lo    = cnt_w;
                st_d.code  = FULL_CODE;
                st_d.phase = PH_HI_SET;
            end
            PH_HI_SET: if (ref_tick) st_d.phase = PH_HI_CNT;
            PH_HI_CNT: if (ref_tick) begin
                st_d.hi    = cnt_w;
                st_d.go    = 1'b1;
                st_d.phase = PH_CALC;
            end
            PH_CALC: if (ref_tick) begin
                st_d.code  = sel_code;
                st_d.fault = sel_fault;
                st_d.done  = 1'b1;
                st_d.phase = PH_APPLY;
            end
            PH_APPLY: if (ref_tick) st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_w   = st_q.phase;
    assign est_w     = st_q.est;
    assign band_code = st_q.code;
    assign busy      = st_q.phase != PH_IDLE;
    assign done      = st_q.done;
    assign cal_fault = st_q.fault;

endmodule

// File: rtl/vco_band_cal_chk.sv
module vco_band_cal_chk
    import band_cal_pkg::*;
#(
    parameter int CODE_W  = 7,
    parameter int CNT_W   = 16,
    parameter int RATIO_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               ref_tick,
    input logic               vco_tick,
    input logic [CODE_W-1:0]  band_code,
    input logic               busy,
    input logic               done,
    input logic               cal_fault,
    input cal_phase_e         phase,
    input logic [RATIO_W-1:0] est_q,
    input logic [CNT_W-1:0]   cnt
);

    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R4
    done_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == PH_APPLY));

    // R2
    lo_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LO_SET || phase == PH_LO_CNT) |-> (band_code == '0));

    // R3
    hi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HI_SET || phase == PH_HI_CNT || phase == PH_CALC) |-> (band_code == '1));

    // R8
    est_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(est_q));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(band_code));

    // R6
    fault_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fault |-> (band_code == MID_CODE));

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1 && vco_tick && !ref_tick) |=> (cnt == '1));

endmodule

bind vco_band_cal vco_band_cal_chk #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .RATIO_W(RATIO_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ref_tick  (ref_tick),
    .vco_tick  (vco_tick),
    .band_code (band_code),
    .busy      (busy),
    .done      (done),
    .cal_fault (cal_fault),
    .phase     (phase_w),
    .est_q     (est_w),
    .cnt       (cnt_w)
);

// File: tb/vco_band_cal_tb_top.sv
module vco_band_cal_tb_top;

    localparam int CODE_W = 7;
    localparam int FULL   = (1 << CODE_W) - 1;
    localparam int MID    = 1 << (CODE_W - 1);
    localparam int SAT    = 65535;
    localparam int PER    = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] est_ratio = '0;
    logic        ref_tick = 1'b0;
    logic        vco_tick = 1'b0;
    logic [6:0]  band_code;
    logic        busy, done, cal_fault;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit armed_cmp = 1'b0;

    always #5 clk = ~clk;

    vco_band_cal dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .est_ratio (est_ratio),
        .ref_tick  (ref_tick),
        .vco_tick  (vco_tick),
        .band_code (band_code),
        .busy      (busy),
        .done      (done),
        .cal_fault (cal_fault)
    );

    function automatic int exp_code(int e, int lo, int hi);
        if (hi <= lo) return MID;
        if (e <= lo)  return 0;
        if (e >= hi)  return FULL;
        return ((e - lo) * FULL + (hi - lo) / 2) / (hi - lo);
    endfunction

    function automatic int cnt_of(int len, int k);
        int c;
        c = (k == 0) ? 0 : (len + k - 1) / k;
        return (c > SAT) ? SAT : c;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: phase 0 idle, 7 armed, 1..6 reference periods.
    int m_phase = 0, m_cnt = 0, m_est = 0, m_lo = 0, m_hi = 0;
    int m_code = 0;
    bit m_done = 0, m_fault = 0;

    always @(posedge clk) begin
        armed_cmp <= 1'b1;
        m_done = 0;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_est = 0; m_lo = 0; m_hi = 0;
            m_code = 0; m_fault = 0;
        end else begin
            case (m_phase)
                0: if (start) begin m_est = est_ratio; m_fault = 0; m_phase = 7; end
                7: if (ref_tick) begin m_code = 0; m_phase = 1; end
                1: if (ref_tick) m_phase = 2;
                2: if (ref_tick) begin m_lo = m_cnt; m_code = FULL; m_phase = 3; end
                3: if (ref_tick) m_phase = 4;
                4: if (ref_tick) begin m_hi = m_cnt; m_phase = 5; end
                5: if (ref_tick) begin
                       m_code = exp_code(m_est, m_lo, m_hi);
                       m_fault = (m_hi <= m_lo);
                       m_done = 1; m_phase = 6;
                   end
                6: if (ref_tick) m_phase = 0;
                default: m_phase = 0;
            endcase
            if (ref_tick) m_cnt = vco_tick ? 1 : 0;
            else if (vco_tick && m_cnt < SAT) m_cnt = m_cnt + 1;
        end
    end

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        string tag;
        cycles++;
        if (armed_cmp) begin
            case (m_phase)
                1, 2:    tag = "R2";
                3, 4, 5: tag = "R3";
                6:       tag = m_fault ? "R6" : "R4";
                default: tag = "R10";
            endcase
            chk(band_code == m_code[6:0], tag, band_code, m_code);
            chk(busy == (m_phase != 0), "R7", busy, m_phase != 0);
            chk(done == m_done, "R7", done, m_done);
            chk(cal_fault == m_fault, "R6", cal_fault, m_fault);
        end
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0; ref_tick = 1'b0; vco_tick = 1'b0;
        end
    endtask

    task automatic period(int len, int k, int st_at, int st_est);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ref_tick = (i == 0);
            vco_tick = (k > 0) && ((i % k) == 0);
            start    = (i == st_at);
            if (i == st_at) est_ratio = 16'(st_est);
        end
    endtask

    // Full calibration: start, arm, six periods, closing strobe.
    task automatic cal(int est_v, int k_lo, int k_hi, int len_hi, int st_at, int st_est, string tag);
        int lo, hi, ec;
        @(negedge clk);
        start = 1'b1; est_ratio = 16'(est_v);
        idle(3);
        period(PER, 2, -1, 0);
        period(PER, k_lo, -1, 0);
        period(PER, 3, st_at, st_est);
        period(len_hi, k_hi, -1, 0);
        period(PER, 3, -1, 0);
        period(PER, 5, -1, 0);
        period(1, 0, -1, 0);
        idle(4);
        lo = cnt_of(PER, k_lo);
        hi = cnt_of(len_hi, k_hi);
        ec = exp_code(est_v, lo, hi);
        chk(band_code == ec[6:0], tag, band_code, ec);
        chk(busy == 1'b0, "R7", busy, 0);
        chk(cal_fault == (hi <= lo), "R6", cal_fault, hi <= lo);
    endtask

    initial begin
        idle(3);
        // R1: reset values while reset is held
        chk(band_code == 0, "R1", band_code, 0);
        chk(busy == 0 && done == 0 && cal_fault == 0, "R1", {busy, done, cal_fault}, 0);
        rst_n = 1'b1;
        idle(3);
        chk(band_code == 0 && !busy, "R1", band_code, 0);

        // R4: interpolation, low 10 and high 40
        cal(25, 4, 1, PER, -1, 0, "R4");
        chk(band_code == 64, "R4", band_code, 64);
        cal(13, 4, 1, PER, -1, 0, "R4");
        // R10: code held while idle
        idle(30);
        chk(band_code == 13, "R10", band_code, 13);
        // R5: clamps, including targets exactly on the endpoints
        cal(5, 4, 1, PER, -1, 0, "R5");
        cal(10, 4, 1, PER, -1, 0, "R5");
        cal(40, 4, 1, PER, -1, 0, "R5");
        cal(900, 4, 1, PER, -1, 0, "R5");
        // R6: high count below low count
        cal(20, 1, 4, PER, -1, 0, "R6");
        chk(band_code == MID, "R6", band_code, MID);
        cal(20, 2, 2, PER, -1, 0, "R6");
        // R8: second start mid-run with another ratio is ignored
        cal(30, 4, 1, PER, 7, 11, "R8");
        // R9: counter saturates in a long high-count period
        cal(30000, 2, 1, 66000, -1, 0, "R9");

        idle(5);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule